// File: doc/BRIEF.md
# ATM receive cell header processor

This block sits between the cell-alignment logic and the receive cell buffer of an ATM receiver. It accepts a byte-wide stream of 53-byte cells, each cell marked by a start-of-cell flag on its first byte. It also takes the current cell delineation state and a handful of static control bits. For every cell it checks the five-byte header, repairs a single-bit header error when that is allowed, and drops idle and unassigned cells. It then decides whether the cell is written into the buffer, presenting the result as a byte stream with a write enable and an end-of-cell flag.

The first five bytes of a cell travel through a five-stage delay line. That line doubles as the header register: when the HEC byte arrives, the whole header is visible at once. The verdict and any corrected bits are loaded back into the line before the first byte reaches the output. As a result, a kept cell produces 53 write enables and a dropped cell produces none. A two-state receive mode decides whether correction is tried. Two saturating counters record how many cells were repaired and how many carried a header error that was not repaired.

Top module: `atm_hdr_proc`

## Requirements
- R1: After reset, `out_we` and `out_eoc` are low, both counters read zero, and the receive mode is the correcting mode.
- R2: A cell is 53 contiguous accepted bytes starting with `in_sop`. A kept cell drives `out_we` for all 53 bytes in order, with `out_eoc` high only on byte 52. A byte accepted at clock edge t appears on the outputs after edge t+4.
- R3: The expected HEC is a CRC-8 with generator x^8+x^2+x+1 and a zero start value, taken over header bytes 0 to 3, most significant bit of byte 0 first. When `cfg_coset` is set, 0x55 is XORed into the received HEC byte before the comparison. When it is clear, the byte is compared as received.
- R4: When `cfg_fix_en` is set and the mode is correcting, a header with exactly one flipped bit (any of the 40 bits, HEC included) is repaired. The repaired bytes are output, and `fixed_cnt` rises by one.
- R5: Any header error moves the mode to detecting, whether or not it was repaired. In detecting mode no error is repaired. An error-free header returns the mode to correcting.
- R6: With `cfg_pass_err` clear, a cell with an unrepaired header error is not written. Every such cell raises `bad_cnt` by one.
- R7: With `cfg_pass_err` set, a cell with an unrepaired header error is written only if `dln_state` is SYNC. The encoding of `dln_state` is HUNT=0, PRESYNC=1, SYNC=2.
- R8: With `cfg_drop_idle` set, a cell is not written when its header, after any repair, is 0x00 0x00 0x00 0x01 with no unrepaired error. The payload plays no part in this. With the bit clear, such a cell is written.
- R9: With `cfg_drop_unas` set, a cell is not written when its header, after any repair, is 0x00 0x00 0x00 0x00 with no unrepaired error. A header that still carries an error is never filtered.
- R10: `fixed_cnt` and `bad_cnt` each hold at their all-ones value instead of wrapping.
- R11: A cell cut short by a new `in_sop` before its fifth byte writes nothing and leaves the mode and counters unchanged. Bytes offered with no cell in progress and no `in_sop` are ignored.
- R12: A header error whose syndrome matches no single-bit position is treated as unrepairable, even in correcting mode with `cfg_fix_en` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid; must stay high for all 53 bytes of a cell |
| in_sop | input | 1 | First byte of a cell |
| in_data | input | 8 | Input cell byte |
| dln_state | input | 2 | Cell delineation state: 0 HUNT, 1 PRESYNC, 2 SYNC |
| cfg_coset | input | 1 | Remove the 0x55 coset from the received HEC byte |
| cfg_fix_en | input | 1 | Allow single-bit header repair |
| cfg_pass_err | input | 1 | Write unrepaired errored cells while in SYNC |
| cfg_drop_idle | input | 1 | Drop idle cells |
| cfg_drop_unas | input | 1 | Drop unassigned cells |
| out_we | output | 1 | Write enable toward the cell buffer |
| out_data | output | 8 | Output cell byte, header repaired when applicable |
| out_eoc | output | 1 | Last byte of a written cell |
| fixed_cnt | output | CNT_W | Saturating count of repaired cells |
| bad_cnt | output | CNT_W | Saturating count of cells with an unrepaired header error |

## Verification
The bench attacks the mode sequencing with two single-bit errors in a row. The second must be dropped, not repaired; a design that ignored the mode would write it and count it as fixed. A flipped HEC bit, a double-bit error and a coset mismatch are each driven. A wrong bit order in the syndrome lookup would damage the output header, and a design that mistook a double-bit error for a single one would write a wrongly repaired cell. Idle and unassigned headers are sent with each filter on and off, with a repaired error, and with an unrepaired error under the pass option, so a filter that ignored header validity or the payload would be caught. A truncated cell, stray bytes and long runs of errors check for leaked partial writes and counter wrap-around.

// File: rtl/atm_rx_pkg.sv
package atm_rx_pkg;

    localparam int CELL_BYTES = 53;
    localparam int HDR_BYTES  = 4;
    localparam int HDR_BITS   = HDR_BYTES * 8;
    localparam int CW_BITS    = HDR_BITS + 8;
    localparam int IDX_W      = $clog2(CELL_BYTES);
    localparam int PIPE_DEPTH = HDR_BYTES + 1;
    localparam logic [7:0] COSET_VAL = 8'h55;
    localparam logic [7:0] HEC_POLY  = 8'h07;

    typedef enum logic [1:0] {
        DLN_HUNT    = 2'd0,
        DLN_PRESYNC = 2'd1,
        DLN_SYNC    = 2'd2
    } dln_e;

    typedef enum logic {
        MODE_CORR = 1'b0,
        MODE_DET  = 1'b1
    } rxmode_e;

    typedef struct packed {
        logic       vld;
        logic       keep;
        logic       eoc;
        logic [7:0] data;
    } stage_t;

    // CRC-8 over the header, MSB of the first byte processed first
    function automatic logic [7:0] hec_crc(input logic [HDR_BITS-1:0] bits);
        logic [7:0] r;
        logic       fb;
        r = '0;
        for (int i = HDR_BITS - 1; i >= 0; i--) begin
            fb = r[7] ^ bits[i];
            r  = {r[6:0], 1'b0};
            if (fb) r = r ^ HEC_POLY;
        end
        return r;
    endfunction

    // Syndrome produced by a single flipped bit at codeword position pos
    // (positions 0..7 are HEC bits, 8.. are header bits)
    function automatic logic [7:0] pos_syndrome(input int pos);
        logic [HDR_BITS-1:0] e;
        logic [7:0]          s;
        e = '0;
        s = '0;
        if (pos < 8) begin
            s[pos] = 1'b1;
        end else begin
            e[pos-8] = 1'b1;
            s = hec_crc(e);
        end
        return s;
    endfunction

endpackage

// File: rtl/atm_hec_chk.sv
module atm_hec_chk
    import atm_rx_pkg::*;
(
    input  logic [HDR_BITS-1:0] hdr_i,
    input  logic [7:0]          hec_i,
    output logic                err_o,
    output logic                fix_ok_o,
    output logic [CW_BITS-1:0]  flip_o
);

    logic [7:0] syn;

    assign syn   = hec_crc(hdr_i) ^ hec_i;
    assign err_o = |syn;

    // one comparator per correctable bit position
    for (genvar j = 0; j < CW_BITS; j++) begin : g_pos
        localparam logic [7:0] SYN_J = pos_syndrome(j);
        assign flip_o[j] = (syn == SYN_J);
    end

    assign fix_ok_o = |flip_o;

endmodule

// File: rtl/atm_hdr_match.sv
module atm_hdr_match
    import atm_rx_pkg::*;
(
    input  logic [HDR_BITS-1:0] hdr_i,
    output logic                idle_o,
    output logic                unas_o
);

    logic upper_zero;

    assign upper_zero = (hdr_i[HDR_BITS-1:8] == '0);
    assign idle_o     = upper_zero & (hdr_i[7:0] == 8'h01);
    assign unas_o     = upper_zero & (hdr_i[7:0] == 8'h00);

endmodule

// File: rtl/atm_hdr_proc.sv
module atm_hdr_proc
    import atm_rx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [7:0]       in_data,
    input  logic [1:0]       dln_state,
    input  logic             cfg_coset,
    input  logic             cfg_fix_en,
    input  logic             cfg_pass_err,
    input  logic             cfg_drop_idle,
    input  logic             cfg_drop_unas,
    output logic             out_we,
    output logic [7:0]       out_data,
    output logic             out_eoc,
    output logic [CNT_W-1:0] fixed_cnt,
    output logic [CNT_W-1:0] bad_cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [IDX_W-1:0] HEC_IDX  = IDX_W'(HDR_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

    typedef struct packed {
        logic [IDX_W-1:0]              idx;
        logic                          in_cell;
        rxmode_e                       mode;
        logic                          cell_keep;
        stage_t [PIPE_DEPTH-1:0]       stg;
        logic [CNT_W-1:0]              fcnt;
        logic [CNT_W-1:0]              bcnt;
    } st_t;

    st_t st_d, st_q;

    // byte position tracking
    logic [IDX_W-1:0] cur_idx;
    logic             acc, at_hec, at_last;

    assign cur_idx = in_sop ? '0 : st_q.idx;
    assign acc     = in_valid & (in_sop | st_q.in_cell);
    assign at_hec  = acc & (cur_idx == HEC_IDX);
    assign at_last = acc & (cur_idx == LAST_IDX);

    // header bytes 0..3 sit in the delay line when the HEC byte arrives
    logic [HDR_BITS-1:0] hdr_rx;
    for (genvar k = 0; k < HDR_BYTES; k++) begin : g_hdr
        assign hdr_rx[HDR_BITS-1-8*k -: 8] = st_q.stg[HDR_BYTES-1-k].data;
    end

    logic [7:0]          hec_cmp;
    logic                err, fix_ok;
    logic [CW_BITS-1:0]  flip;

    assign hec_cmp = in_data ^ (cfg_coset ? COSET_VAL : 8'h00);

    atm_hec_chk i_hec_chk (
        .hdr_i    (hdr_rx),
        .hec_i    (hec_cmp),
        .err_o    (err),
        .fix_ok_o (fix_ok),
        .flip_o   (flip)
    );

    logic                do_fix, unfixed;
    logic [CW_BITS-1:0]  cw_fix;
    logic [HDR_BITS-1:0] hdr_fix;
    logic [7:0]          hec_fix;
    logic                is_idle, is_unas, drop_flt, keep_new;

    assign do_fix  = err & cfg_fix_en & (st_q.mode == MODE_CORR) & fix_ok;
    assign unfixed = err & ~do_fix;
    assign cw_fix  = {hdr_rx, in_data} ^ (do_fix ? flip : '0);
    assign hdr_fix = cw_fix[CW_BITS-1:8];
    assign hec_fix = cw_fix[7:0];

    atm_hdr_match i_hdr_match (
        .hdr_i  (hdr_fix),
        .idle_o (is_idle),
        .unas_o (is_unas)
    );

    assign drop_flt = ~unfixed & ((cfg_drop_idle & is_idle) | (cfg_drop_unas & is_unas));
    assign keep_new = unfixed ? (cfg_pass_err & (dln_state == DLN_SYNC)) : ~drop_flt;

    always_comb begin
        st_d = st_q;
        if (acc) begin
            st_d.idx     = cur_idx + 1'b1;
            st_d.in_cell = ~at_last;
        end
        // shift the delay line every cycle
        st_d.stg[0].vld  = acc;
        st_d.stg[0].keep = st_q.cell_keep & (cur_idx > HEC_IDX);
        st_d.stg[0].eoc  = at_last;
        st_d.stg[0].data = in_data;
        for (int k = 1; k < PIPE_DEPTH; k++) begin
            st_d.stg[k] = st_q.stg[k-1];
        end
        // on the HEC byte, reload the header with the verdict and repair
        if (at_hec) begin
            st_d.cell_keep = keep_new;
            for (int k = 0; k < HDR_BYTES; k++) begin
                st_d.stg[PIPE_DEPTH-1-k].vld  = 1'b1;
                st_d.stg[PIPE_DEPTH-1-k].keep = keep_new;
                st_d.stg[PIPE_DEPTH-1-k].eoc  = 1'b0;
                st_d.stg[PIPE_DEPTH-1-k].data = hdr_fix[HDR_BITS-1-8*k -: 8];
            end
            st_d.stg[0].vld  = 1'b1;
            st_d.stg[0].keep = keep_new;
            st_d.stg[0].eoc  = 1'b0;
            st_d.stg[0].data = hec_fix;
            st_d.mode = err ? MODE_DET : MODE_CORR;
            if (do_fix && st_q.fcnt != CNT_MAX) st_d.fcnt = st_q.fcnt + 1'b1;
            if (unfixed && st_q.bcnt != CNT_MAX) st_d.bcnt = st_q.bcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_we    = st_q.stg[PIPE_DEPTH-1].vld & st_q.stg[PIPE_DEPTH-1].keep;
    assign out_data  = st_q.stg[PIPE_DEPTH-1].data;
    assign out_eoc   = out_we & st_q.stg[PIPE_DEPTH-1].eoc;
    assign fixed_cnt = st_q.fcnt;
    assign bad_cnt   = st_q.bcnt;

    // ---------------- assertions ----------------
    AST_IN_CONTIG: assert property (@(posedge clk) disable iff (!rst_n) st_q.in_cell |-> in_valid); // R2
    AST_MODE_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n) (at_hec && err) |=> (st_q.mode == MODE_DET)); // R5
    AST_DET_ERR_UNFIXED: assert property (@(posedge clk) disable iff (!rst_n) (at_hec && err && st_q.mode == MODE_DET) |=> (st_q.bcnt == CNT_MAX || st_q.bcnt == $past(st_q.bcnt) + 1'b1)); // R5
    AST_FLIP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) at_hec |-> $onehot0(flip)); // R4
    AST_FCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (st_q.fcnt == $past(st_q.fcnt) || st_q.fcnt == $past(st_q.fcnt) + 1'b1)); // R10
    AST_FCNT_SAT: assert property (@(posedge clk) disable iff (!rst_n) (st_q.fcnt == CNT_MAX) |=> (st_q.fcnt == CNT_MAX)); // R10
    AST_BCNT_SAT: assert property (@(posedge clk) disable iff (!rst_n) (st_q.bcnt == CNT_MAX) |=> (st_q.bcnt == CNT_MAX)); // R10

endmodule

// File: tb/test_atm_hdr_proc.sv
module test_atm_hdr_proc;

    localparam int CW   = 3;
    localparam int CMAX = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_sop = 1'b0;
    logic [7:0]    in_data = 8'h00;
    logic [1:0]    dln_state = 2'd2;
    logic          cfg_coset = 1'b0, cfg_fix_en = 1'b0, cfg_pass_err = 1'b0;
    logic          cfg_drop_idle = 1'b0, cfg_drop_unas = 1'b0;
    logic          out_we, out_eoc;
    logic [7:0]    out_data;
    logic [CW-1:0] fixed_cnt, bad_cnt;

    always #5 clk = ~clk;

    atm_hdr_proc #(.CNT_W(CW)) i_atm_hdr_proc (
        .clk, .rst_n, .in_valid, .in_sop, .in_data, .dln_state,
        .cfg_coset, .cfg_fix_en, .cfg_pass_err, .cfg_drop_idle, .cfg_drop_unas,
        .out_we, .out_data, .out_eoc, .fixed_cnt, .bad_cnt
    );

    int checks = 0, errors = 0;
    bit run_cmp = 1'b0;

    // reference model state
    bit bdet = 1'b0;
    int bfix = 0, bbad = 0;

    // expected output for the byte driven this cycle, then a 5-edge delay
    logic       exp_we_n = 1'b0, exp_eoc_n = 1'b0;
    logic [7:0] exp_dat_n = 8'h00;
    int         exp_tag_n = 0;
    logic       exp_we[5], exp_eoc[5];
    logic [7:0] exp_dat[5];
    int         exp_tag[5];

    initial begin
        for (int k = 0; k < 5; k++) begin
            exp_we[k] = 1'b0; exp_eoc[k] = 1'b0; exp_dat[k] = 8'h00; exp_tag[k] = 0;
        end
    end

    always @(posedge clk) begin
        for (int k = 4; k > 0; k--) begin
            exp_we[k]  <= exp_we[k-1];
            exp_eoc[k] <= exp_eoc[k-1];
            exp_dat[k] <= exp_dat[k-1];
            exp_tag[k] <= exp_tag[k-1];
        end
        exp_we[0]  <= exp_we_n;
        exp_eoc[0] <= exp_eoc_n;
        exp_dat[0] <= exp_dat_n;
        exp_tag[0] <= exp_tag_n;
    end

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            checks++;
            if (out_we !== exp_we[4] || out_eoc !== exp_eoc[4] ||
                (exp_we[4] && out_data !== exp_dat[4])) begin
                errors++;
                $display("FAIL R%0d out we/eoc/data=%0b/%0b/%02h expected %0b/%0b/%02h",
                         exp_tag[4], out_we, out_eoc, out_data, exp_we[4], exp_eoc[4], exp_dat[4]);
            end
        end
    end

    function automatic logic [7:0] ref_crc(input logic [31:0] m);
        logic [7:0] r;
        r = 8'h00;
        for (int i = 31; i >= 0; i--) begin
            if (r[7] != m[i]) r = {r[6:0], 1'b0} ^ 8'h07;
            else              r = {r[6:0], 1'b0};
        end
        return r;
    endfunction

    function automatic logic [7:0] good_hec(input logic [31:0] h);
        return ref_crc(h) ^ (cfg_coset ? 8'h55 : 8'h00);
    endfunction

    task automatic drive(input logic v, input logic s, input logic [7:0] d,
                         input logic ew, input logic [7:0] ed, input logic ee, input int tag);
        @(negedge clk);
        in_valid = v; in_sop = s; in_data = d;
        exp_we_n = ew; exp_dat_n = ed; exp_eoc_n = ee; exp_tag_n = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 0);
    endtask

    task automatic send_cell(input logic [31:0] hdr, input logic [7:0] hec,
                             input logic [7:0] pseed, input int tag);
        logic [39:0] cw, t, fixed_cw;
        logic [7:0]  cos, orig, expd;
        logic        err, fixed, unf, flt, keep;
        cos = cfg_coset ? 8'h55 : 8'h00;
        cw  = {hdr, hec};
        err = (ref_crc(hdr) != (hec ^ cos));
        fixed = 1'b0;
        fixed_cw = cw;
        if (err && cfg_fix_en && !bdet) begin
            for (int p = 0; p < 40; p++) begin
                t = cw ^ (40'd1 << p);
                if (!fixed && ref_crc(t[39:8]) == (t[7:0] ^ cos)) begin
                    fixed = 1'b1; fixed_cw = t;
                end
            end
        end
        unf  = err && !fixed;
        bdet = err;
        flt  = !unf && ((cfg_drop_idle && fixed_cw[39:8] == 32'h1) ||
                        (cfg_drop_unas && fixed_cw[39:8] == 32'h0));
        keep = unf ? (cfg_pass_err && dln_state == 2'd2) : !flt;
        if (fixed && bfix < CMAX) bfix++;
        if (unf && bbad < CMAX) bbad++;
        for (int i = 0; i < 53; i++) begin
            if (i < 5) begin
                orig = cw[39-8*i -: 8];
                expd = fixed_cw[39-8*i -: 8];
            end else begin
                orig = pseed + 8'(i);
                expd = orig;
            end
            drive(1'b1, i == 0, orig, keep, expd, keep && i == 52, tag);
        end
    endtask

    task automatic chk_cnt(input int tag);
        idle(1);
        checks++;
        if (fixed_cnt !== CW'(bfix) || bad_cnt !== CW'(bbad)) begin
            errors++;
            $display("FAIL R%0d counters fixed/bad=%0d/%0d expected %0d/%0d",
                     tag, fixed_cnt, bad_cnt, bfix, bbad);
        end
    endtask

    bit done = 1'b0;

    initial begin
        logic [31:0] h;
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        run_cmp = 1'b1;
        // R1: reset state
        checks++;
        if (out_we !== 1'b0 || out_eoc !== 1'b0 || fixed_cnt !== '0 || bad_cnt !== '0) begin
            errors++;
            $display("FAIL R1 reset we/eoc/fixed/bad=%0b/%0b/%0d/%0d expected 0/0/0/0",
                     out_we, out_eoc, fixed_cnt, bad_cnt);
        end
        // R2 R3: clean cells, back to back, then a gap
        send_cell(32'h0123_4560, good_hec(32'h0123_4560), 8'h10, 2);
        send_cell(32'hA5A5_0F02, good_hec(32'hA5A5_0F02), 8'h80, 2);
        idle(3);
        send_cell(32'hFFFF_FFF0, good_hec(32'hFFFF_FFF0), 8'hC0, 3);
        idle(2);
        // R3: coset on, good and coset-less HEC
        cfg_coset = 1'b1;
        send_cell(32'h1000_0020, good_hec(32'h1000_0020), 8'h33, 3);
        send_cell(32'h1000_0020, ref_crc(32'h1000_0020), 8'h34, 6); // R6 dropped
        chk_cnt(6);
        send_cell(32'h2200_0040, good_hec(32'h2200_0040), 8'h44, 5); // R5 back to correcting
        // R4: single-bit header repair
        cfg_fix_en = 1'b1;
        h = 32'h0A0B_0C0D;
        send_cell(h ^ 32'h0000_0400, good_hec(h), 8'h55, 4);
        chk_cnt(4);
        send_cell(h ^ 32'h0100_0000, good_hec(h), 8'h56, 5); // R5 detecting: no repair
        chk_cnt(5);
        send_cell(h, good_hec(h), 8'h57, 5);
        send_cell(h, good_hec(h) ^ 8'h10, 8'h58, 4); // R4 HEC bit
        send_cell(h, good_hec(h), 8'h59, 5);
        // R12: double-bit error in correcting mode
        send_cell(h ^ 32'h0000_0003, good_hec(h), 8'h5A, 12);
        send_cell(h, good_hec(h), 8'h5B, 12);
        chk_cnt(12);
        // R7: pass errored cells only in SYNC
        cfg_fix_en = 1'b0; cfg_pass_err = 1'b1;
        send_cell(h, good_hec(h) ^ 8'h01, 8'h60, 7);
        dln_state = 2'd1;
        send_cell(h, good_hec(h) ^ 8'h01, 8'h61, 7);
        dln_state = 2'd0;
        send_cell(h, good_hec(h) ^ 8'h01, 8'h62, 7);
        dln_state = 2'd2;
        chk_cnt(7);
        // R9: unassigned with unrepaired error is not filtered
        cfg_drop_unas = 1'b1;
        send_cell(32'h0, good_hec(32'h0) ^ 8'h03, 8'h63, 9);
        cfg_pass_err = 1'b0; cfg_fix_en = 1'b1;
        send_cell(h, good_hec(h), 8'h64, 9);
        // R8 R9: filters
        cfg_drop_unas = 1'b0; cfg_drop_idle = 1'b1;
        send_cell(32'h1, good_hec(32'h1), 8'h70, 8);
        send_cell(32'h0, good_hec(32'h0), 8'h71, 9);
        cfg_drop_idle = 1'b0;
        send_cell(32'h1, good_hec(32'h1), 8'h72, 8);
        cfg_drop_unas = 1'b1;
        send_cell(32'h0, good_hec(32'h0), 8'h73, 9);
        send_cell(32'h1, good_hec(32'h1), 8'h74, 9);
        cfg_drop_idle = 1'b1;
        send_cell(32'h1 ^ 32'h0000_8000, good_hec(32'h1), 8'h75, 8); // repaired then dropped
        chk_cnt(8);
        send_cell(h, good_hec(h), 8'h76, 8);
        // R11: truncated cell and stray bytes
        drive(1'b1, 1'b1, 8'h01, 1'b0, 8'h00, 1'b0, 11);
        drive(1'b1, 1'b0, 8'h02, 1'b0, 8'h00, 1'b0, 11);
        drive(1'b1, 1'b0, 8'h03, 1'b0, 8'h00, 1'b0, 11);
        send_cell(h, good_hec(h), 8'h77, 11);
        idle(1);
        for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 8'hAA, 1'b0, 8'h00, 1'b0, 11);
        chk_cnt(11);
        // R10: saturation of both counters
        for (int i = 0; i < 8; i++) begin
            send_cell(h, good_hec(h), 8'(i), 10);
            send_cell(h ^ (32'h1 << i), good_hec(h), 8'(i + 8), 10);
        end
        for (int i = 0; i < 8; i++) send_cell(h ^ 32'h0000_0300, good_hec(h), 8'(i), 10);
        idle(6);
        chk_cnt(10);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule